// File: doc/BRIEF.md
# 5B Symbol Aligner and Decoder

This block sits on the receive side of a 100 Mb/s block-coded link, after the stage that removes scrambling. It takes a serial bit stream with no known code-group boundary, one bit per cycle when `bit_vld` is high. It waits for a run of idle (all-ones) code groups followed by the start delimiter pair J then K. It locks its 5-bit symbol boundary to the end of that pair. From then on it turns each 5-bit code group into a 4-bit nibble for the MAC.

The delimiter pair itself is not decoded. It is presented as two preamble nibbles, and the frame-valid signal rises with the first of them. Decoding continues until the end delimiter pair T then R. At that point the frame-valid signal drops and the block goes back to hunting. Code groups that are neither data nor a proper end pair are passed on as error nibbles.

The controller has four states:
- `ST_HUNT`: searching for idle followed by J/K.
- `ST_PRE_K`: issuing the second preamble nibble.
- `ST_DATA`: decoding symbols.
- `ST_WAIT_R`: a T has arrived and the block is checking the next symbol for R.

Transitions:
- `ST_HUNT` to `ST_PRE_K` on a qualified J/K match.
- `ST_PRE_K` to `ST_DATA` unconditionally after one cycle.
- `ST_DATA` to `ST_WAIT_R` when a symbol equal to T completes.
- `ST_WAIT_R` to `ST_HUNT` when the next symbol completes, whether or not it is R.

Top module: `sym5b_rx_align`

## Requirements
- R1: After reset `nib_vld`, `frame_dv`, `rx_err` and `nib_out` are all zero and the block is hunting.
- R2: The 10-bit pattern 1100010001 is recognised at any bit offset, with the first received bit being the leftmost. Every later symbol is the next 5 accepted bits counted from the last bit of that match, leftmost bit received first.
- R3: A J/K match starts a frame only if the IDLE_SYMS*5 accepted bits (default 10) just before it are all ones. Otherwise the match is ignored: `frame_dv` and `nib_vld` stay low.
- R4: A qualified match produces two nibbles of value 0101 with `nib_vld` high, in the two cycles after the cycle in which the last K bit is accepted. `frame_dv` rises with the first of them.
- R5: Each data code group is mapped to its nibble by the 4B/5B data table:
  - 0:11110, 1:01001, 2:10100, 3:10101
  - 4:01010, 5:01011, 6:01110, 7:01111
  - 8:10010, 9:10011, A:10110, B:10111
  - C:11010, D:11011, E:11100, F:11101
- R6: Inside a frame, any code group that is not data and not T gives a nibble of 0000 with `rx_err` high, and the frame continues. This includes idle 11111, a lone R 00111, J and K.
- R7: When T (01101) is immediately followed by R (00111), no nibble is produced for either symbol. `frame_dv` goes low in the cycle after the last R bit is accepted, and hunting resumes.
- R8: When T is followed by any symbol other than R, one nibble 0000 with `rx_err` high is produced in the cycle after that symbol completes. `frame_dv` drops one cycle later and hunting resumes.
- R9: A cycle with `bit_vld` low accepts no bit and does not advance the symbol boundary or the state.
- R10: A decoded nibble appears in the cycle after its fifth bit is accepted, with `nib_vld` high for that single cycle.
- R11: After a frame ends, a new frame needs a fresh idle run followed by J/K. Bits left over from the old frame never qualify a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | A received bit is present this cycle |
| bit_in | input | 1 | Received bit, unaligned |
| nib_out | output | 4 | Decoded nibble, zero when not valid |
| nib_vld | output | 1 | One-cycle strobe for `nib_out` |
| frame_dv | output | 1 | High from the first preamble nibble to frame end |
| rx_err | output | 1 | Error flag for the current nibble |

## Verification
The assertions assume that bits arrive at most one per cycle, and that `bit_vld` and `bit_in` are free of X once reset is released. The stimulus drives every bit from a task on the falling edge, so neither input is ever undriven after reset. With gaps enabled it inserts zero to two empty cycles between bits, which exercises the hold behaviour without ever presenting two bits in one cycle. Frames are always built from whole 5-bit groups after J/K, so that the end pair lands on a symbol boundary, as a well-formed stream would.

// File: rtl/s5r_pkg.sv
package s5r_pkg;

    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    localparam logic [SYM_W-1:0] CODE_J = 5'b11000;
    localparam logic [SYM_W-1:0] CODE_K = 5'b10001;
    localparam logic [SYM_W-1:0] CODE_T = 5'b01101;
    localparam logic [SYM_W-1:0] CODE_R = 5'b00111;
    localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;

    typedef enum logic [1:0] {
        SK_DATA,
        SK_END_T,
        SK_END_R,
        SK_BAD
    } sym_kind_e;

    typedef struct packed {
        sym_kind_e        kind;
        logic [NIB_W-1:0] nib;
    } sym_info_t;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_PRE_K,
        ST_DATA,
        ST_WAIT_R
    } fsm_e;

    function automatic sym_info_t decode_5b(input logic [SYM_W-1:0] code);
        sym_info_t r;
        r.kind = SK_DATA;
        r.nib  = '0;
        unique case (code)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            CODE_T:   r.kind = SK_END_T;
            CODE_R:   r.kind = SK_END_R;
            default:  r.kind = SK_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/s5r_window.sv
module s5r_window
    import s5r_pkg::*;
#(
    parameter int IDLE_SYMS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic             jk_hit,
    output logic [SYM_W-1:0] last_sym
);

    localparam int PAIR_W = 2 * SYM_W;
    localparam int WIN_W  = (IDLE_SYMS + 2) * SYM_W;

    logic [WIN_W-2:0] hist_q;
    logic [WIN_W-1:0] win_nxt;
    logic             idle_ok;
    logic             pair_ok;

    assign win_nxt  = {hist_q, bit_in};
    assign last_sym = win_nxt[SYM_W-1:0];
    assign pair_ok  = (win_nxt[PAIR_W-1:0] == {CODE_J, CODE_K});

    generate
        if (IDLE_SYMS > 0) begin : g_idle_chk
            assign idle_ok = &win_nxt[WIN_W-1:PAIR_W];
        end else begin : g_idle_none
            assign idle_ok = 1'b1;
        end
    endgenerate

    assign jk_hit = bit_vld && pair_ok && idle_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (bit_vld) begin
            hist_q <= win_nxt[WIN_W-2:0];
        end
    end

endmodule

// File: rtl/s5r_symcnt.sv
module s5r_symcnt
    import s5r_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic sym_done
);

    localparam int CW = $clog2(SYM_W);
    localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);

    logic [CW-1:0] cnt_q;

    assign sym_done = advance && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= sym_done ? '0 : cnt_q + 1'b1;
        end
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_hold_no_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(cnt_q));

endmodule

// File: rtl/s5r_decode.sv
module s5r_decode
    import s5r_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output sym_kind_e        kind,
    output logic [NIB_W-1:0] nib
);

    sym_info_t info;

    always_comb begin
        info = decode_5b(sym);
        kind = info.kind;
        nib  = info.nib;
    end

endmodule

// File: rtl/sym5b_rx_align.sv
module sym5b_rx_align
    import s5r_pkg::*;
#(
    parameter int IDLE_SYMS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_in,
    output logic [3:0] nib_out,
    output logic       nib_vld,
    output logic       frame_dv,
    output logic       rx_err
);

    fsm_e             st_q, st_d;
    logic             jk_hit;
    logic [SYM_W-1:0] last_sym;
    logic             sym_done;
    sym_kind_e        kind;
    logic [NIB_W-1:0] dec_nib;

    logic             vld_d, dv_d, err_d;
    logic [NIB_W-1:0] nib_d;

    s5r_window #(.IDLE_SYMS(IDLE_SYMS)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .jk_hit   (jk_hit),
        .last_sym (last_sym)
    );

    s5r_symcnt u_symcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (st_q == ST_HUNT),
        .advance  (bit_vld && (st_q != ST_HUNT)),
        .sym_done (sym_done)
    );

    s5r_decode u_decode (
        .sym  (last_sym),
        .kind (kind),
        .nib  (dec_nib)
    );

    // Next state and next outputs
    always_comb begin
        st_d  = st_q;
        vld_d = 1'b0;
        err_d = 1'b0;
        nib_d = '0;
        dv_d  = frame_dv;
        unique case (st_q)
            ST_HUNT: begin
                dv_d = 1'b0;
                if (jk_hit) begin
                    st_d  = ST_PRE_K;
                    vld_d = 1'b1;
                    nib_d = PRE_NIB;
                    dv_d  = 1'b1;
                end
            end
            ST_PRE_K: begin
                st_d  = ST_DATA;
                vld_d = 1'b1;
                nib_d = PRE_NIB;
                dv_d  = 1'b1;
            end
            ST_DATA: begin
                if (sym_done) begin
                    unique case (kind)
                        SK_END_T: st_d = ST_WAIT_R;
                        SK_DATA: begin
                            vld_d = 1'b1;
                            nib_d = dec_nib;
                        end
                        default: begin
                            vld_d = 1'b1;
                            err_d = 1'b1;
                        end
                    endcase
                end
            end
            ST_WAIT_R: begin
                if (sym_done) begin
                    st_d = ST_HUNT;
                    if (kind == SK_END_R) begin
                        dv_d = 1'b0;
                    end else begin
                        vld_d = 1'b1;
                        err_d = 1'b1;
                        dv_d  = 1'b1;
                    end
                end
            end
            default: st_d = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nib_vld  <= 1'b0;
            nib_out  <= '0;
            rx_err   <= 1'b0;
            frame_dv <= 1'b0;
        end else begin
            nib_vld  <= vld_d;
            nib_out  <= nib_d;
            rx_err   <= err_d;
            frame_dv <= dv_d;
        end
    end

    assert_vld_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nib_vld |-> frame_dv);

    assert_err_nibble_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> (nib_vld && nib_out == 4'h0));

    assert_first_preamble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_dv) |-> (nib_vld && nib_out == PRE_NIB && !rx_err));

    assert_second_preamble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_dv) |=> (nib_vld && nib_out == PRE_NIB));

    assert_idle_cycle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && (st_q == ST_DATA || st_q == ST_WAIT_R)) |=> !nib_vld);

    assert_hunt_drops_dv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HUNT && !jk_hit) |=> !frame_dv);

    assert_fall_only_to_hunt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_dv) |-> (st_q == ST_HUNT));

endmodule

// File: tb/sym5b_rx_align_tb_top.sv
module sym5b_rx_align_tb_top;

    localparam int IDLE_BITS = 10;
    localparam int WIN_BITS  = IDLE_BITS + 10;
    localparam logic [9:0] JK_PAT = 10'b1100010001;
    localparam logic [4:0] T_SYM  = 5'b01101;
    localparam logic [4:0] R_SYM  = 5'b00111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic [3:0] nib_out;
    logic       nib_vld, frame_dv, rx_err;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    finished = 1'b0;
    bit    armed = 1'b0;
    bit    gap_on = 1'b0;
    int    lfsr = 32'h1ace;
    string tag = "R1";

    int         hq[$];
    int         mode = 0;
    int         bc = 0;
    logic       e_vld = 0, e_dv = 0, e_err = 0;
    logic [3:0] e_nib = 0;

    always #2.5 clk = ~clk;

    sym5b_rx_align dut_i (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .nib_out(nib_out), .nib_vld(nib_vld), .frame_dv(frame_dv), .rx_err(rx_err)
    );

    function automatic logic [4:0] enc5(input int n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic int lookup(input logic [4:0] s);
        for (int n = 0; n < 16; n++) if (enc5(n) == s) return n;
        return -1;
    endfunction

    function automatic bit model_match();
        if (hq.size() != WIN_BITS) return 0;
        for (int i = 0; i < WIN_BITS; i++) begin
            int want;
            want = (i < IDLE_BITS) ? 1 : int'(JK_PAT[9 - (i - IDLE_BITS)]);
            if (hq[i] != want) return 0;
        end
        return 1;
    endfunction

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            hq.delete(); mode = 0; bc = 0;
            e_vld = 0; e_dv = 0; e_err = 0; e_nib = 0;
        end else begin
            logic [4:0] s;
            int v;
            armed = 1'b1;
            e_vld = 0; e_err = 0; e_nib = 0;
            if (bit_vld) begin
                hq.push_back(int'(bit_in));
                if (hq.size() > WIN_BITS) void'(hq.pop_front());
            end
            s = 0;
            if (hq.size() >= 5)
                for (int i = 0; i < 5; i++) s[4 - i] = hq[hq.size() - 5 + i][0];
            case (mode)
                0: begin
                    e_dv = 0;
                    if (bit_vld && model_match()) begin
                        e_vld = 1; e_nib = 4'b0101; e_dv = 1; mode = 1; bc = 0;
                    end
                end
                1: begin
                    e_vld = 1; e_nib = 4'b0101; e_dv = 1; mode = 2;
                    if (bit_vld) bc++;
                end
                2, 3: begin
                    if (bit_vld) begin
                        bc++;
                        if (bc == 5) begin
                            bc = 0;
                            if (mode == 3) begin
                                mode = 0;
                                if (s != R_SYM) begin e_vld = 1; e_err = 1; end
                                else e_dv = 0;
                            end else if (s == T_SYM) begin
                                mode = 3;
                            end else begin
                                v = lookup(s);
                                e_vld = 1;
                                if (v < 0) e_err = 1;
                                else e_nib = v[3:0];
                            end
                        end
                    end
                end
                default: mode = 0;
            endcase
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (armed && !finished) begin
            checks++;
            if (nib_vld !== e_vld || frame_dv !== e_dv || rx_err !== e_err ||
                (e_vld && nib_out !== e_nib)) begin
                fails++;
                $display("FAIL %s: vld/dv/err/nib actual %b %b %b %h expected %b %b %b %h at cycle %0d",
                         tag, nib_vld, frame_dv, rx_err, nib_out, e_vld, e_dv, e_err, e_nib, cyc);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic put_bit(input logic b);
        if (gap_on) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
            repeat (lfsr % 3) begin @(negedge clk); bit_vld = 1'b0; end
        end
        @(negedge clk); bit_vld = 1'b1; bit_in = b;
    endtask

    task automatic put_sym(input logic [4:0] s);
        for (int i = 4; i >= 0; i--) put_bit(s[i]);
    endtask

    task automatic put_ones(input int n);
        for (int i = 0; i < n; i++) put_bit(1'b1);
    endtask

    task automatic put_jk();
        put_sym(5'b11000); put_sym(5'b10001);
    endtask

    task automatic quiet(input int n);
        repeat (n) begin @(negedge clk); bit_vld = 1'b0; end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset
        checks++;
        if (nib_vld !== 0 || frame_dv !== 0 || rx_err !== 0 || nib_out !== 0) begin
            fails++;
            $display("FAIL R1: actual %b %b %b %h expected 0 0 0 0", nib_vld, frame_dv, rx_err, nib_out);
        end
        quiet(3);

        // R3: too little idle, then no idle at all
        tag = "R3";
        put_ones(7); put_jk(); put_sym(enc5(3));
        put_sym(5'b00100); put_sym(5'b01010); put_jk(); put_sym(enc5(4));
        quiet(4);

        // R2 with a 3-bit offset, R4 preamble, R5 full table, R7 clean end
        tag = "R2";
        put_ones(13);
        tag = "R4";
        put_jk();
        tag = "R5";
        for (int n = 0; n < 16; n++) put_sym(enc5(n));
        tag = "R7";
        put_sym(T_SYM); put_sym(R_SYM);
        quiet(4);

        // R10: short frame, latency per nibble
        tag = "R10";
        put_ones(10); put_jk(); put_sym(enc5(10)); put_sym(enc5(11));
        put_sym(T_SYM); put_sym(R_SYM);
        quiet(3);

        // R9: random empty cycles between bits
        tag = "R9";
        gap_on = 1'b1;
        put_ones(11); put_jk();
        for (int n = 15; n >= 0; n--) put_sym(enc5(n));
        put_sym(T_SYM); put_sym(R_SYM);
        gap_on = 1'b0;
        quiet(4);

        // R6: invalid groups inside a frame
        tag = "R6";
        put_ones(12); put_jk(); put_sym(enc5(7));
        put_sym(5'b00000); put_sym(5'b11111); put_sym(R_SYM);
        put_sym(5'b11000); put_sym(5'b10001); put_sym(enc5(9));
        put_sym(T_SYM); put_sym(R_SYM);
        quiet(4);

        // R8: T followed by data
        tag = "R8";
        put_ones(10); put_jk(); put_sym(enc5(1));
        put_sym(T_SYM); put_sym(enc5(0));
        put_sym(enc5(2)); put_sym(enc5(3));
        quiet(4);

        // R11: restart requires fresh idle
        tag = "R11";
        put_ones(10); put_jk(); put_sym(enc5(4)); put_sym(T_SYM); put_sym(R_SYM);
        put_jk(); put_sym(enc5(5));
        put_ones(10); put_jk(); put_sym(enc5(6)); put_sym(T_SYM); put_sym(R_SYM);
        quiet(6);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule